// File: doc/BRIEF.md
# Electronic Dice Game Controller

This block runs a complete two-dice game of chance. It has a state machine that applies the scoring rules and a small datapath. The datapath holds two face counters, an adder, a few sum decoders and a point register. While the player holds the roll button, the two counters spin at clock rate. The first counter steps on every clock, and the second steps each time the first wraps, so all 36 face pairs come up in turn. When the button is released, the counters freeze and the sum of the faces is judged in the following clock cycle.

An opening roll wins on 7 or 11 and loses on 2, 3 or 12. Any other opening sum becomes the point, and the player rolls again. A later roll wins when it matches the point and loses on 7. Any other later sum asks for another roll. A decided game keeps its light on and ignores the button until reset starts a new game.

Top module: `dice_game`

## Requirements
- R1: A synchronous, active-high reset sets both dice to 1, clears the point to 0, switches both lights off and waits for an opening roll.
- R2: While the roll button is high and the game is undecided, die A advances 1→2→…→6→1 on every clock. Die B advances in the same way only on the clock where die A wraps from 6 to 1, so 36 held clocks return the pair to its starting faces.
- R3: While the button is low, both dice hold their values.
- R4: An opening roll whose sum is 7 or 11 lights the win output.
- R5: An opening roll whose sum is 2, 3 or 12 lights the lose output.
- R6: An opening roll with any other sum stores that sum in the point register and lights nothing. The point register changes at no other time except reset.
- R7: A later roll whose sum equals the point lights the win output.
- R8: A later roll that sums to 7 lights the lose output. Any other later sum lights nothing and leaves the point unchanged.
- R9: Once either light is on, the button has no effect: the dice, the point and both lights hold until reset.
- R10: The win and lose outputs are never high together.
- R11: A roll is one press followed by one release. The sum is judged on the first clock edge that samples the button low after it was high. A light or a new point shows on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts a new game |
| roll_btn | input | 1 | Roll button, high while held |
| win | output | 1 | Win light |
| lose | output | 1 | Lose light |
| die_a | output | 3 | Face of die A, 1 to 6 |
| die_b | output | 3 | Face of die B, 1 to 6 |
| point | output | 4 | Stored point, 0 until an opening roll sets it |

## Verification
The assertions assume that the roll button is a clean, synchronous level that changes only between clock edges, with no bounce and no glitches. They also assume that reset is held for at least one clock edge. The bench changes the button only on falling clock edges and pulses reset for one full cycle. To reach each target sum, it chooses the number of held clocks from the current faces, so every scoring branch is reached by legal stimulus alone.

// File: rtl/dice_game.sv
module dice_game #(
  parameter int FACES = 6,
  localparam int DW = $clog2(FACES + 1),
  localparam int SW = $clog2(2 * FACES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          roll_btn,
  output logic          win,
  output logic          lose,
  output logic [DW-1:0] die_a,
  output logic [DW-1:0] die_b,
  output logic [SW-1:0] point
);

  typedef enum logic [2:0] {
    OPEN_WAIT, OPEN_HELD, NEXT_WAIT, NEXT_HELD, GAME_WON, GAME_LOST
  } phase_t;

  phase_t phase, phase_nx;
  logic [SW-1:0] sum;
  logic spin, keep_pt;
  logic is7, is7or11, craps, hit_pt;

  assign sum      = SW'(die_a) + SW'(die_b);
  assign is7      = (sum == SW'(7));
  assign is7or11  = is7 || (sum == SW'(11));
  assign craps    = (sum == SW'(2)) || (sum == SW'(3)) || (sum == SW'(12));
  assign hit_pt   = (sum == point);

  assign spin = roll_btn && (phase != GAME_WON) && (phase != GAME_LOST);
  assign win  = (phase == GAME_WON);
  assign lose = (phase == GAME_LOST);

  always_comb begin
    phase_nx = phase;
    keep_pt  = 1'b0;
    case (phase)
      OPEN_WAIT: if (roll_btn) phase_nx = OPEN_HELD;
      OPEN_HELD:
        if (!roll_btn) begin
          if (is7or11)    phase_nx = GAME_WON;
          else if (craps) phase_nx = GAME_LOST;
          else begin
            phase_nx = NEXT_WAIT;
            keep_pt  = 1'b1;
          end
        end
      NEXT_WAIT: if (roll_btn) phase_nx = NEXT_HELD;
      NEXT_HELD:
        if (!roll_btn) begin
          if (hit_pt)   phase_nx = GAME_WON;
          else if (is7) phase_nx = GAME_LOST;
          else          phase_nx = NEXT_WAIT;
        end
      default: phase_nx = phase;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= OPEN_WAIT;
      die_a <= DW'(1);
      die_b <= DW'(1);
      point <= '0;
    end else begin
      phase <= phase_nx;
      if (keep_pt) point <= sum;
      if (spin) begin
        if (die_a == DW'(FACES)) begin
          die_a <= DW'(1);
          die_b <= (die_b == DW'(FACES)) ? DW'(1) : die_b + DW'(1);
        end else begin
          die_a <= die_a + DW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/dice_game_chk.sv
module dice_game_chk #(
  parameter int FACES = 6,
  localparam int DW = $clog2(FACES + 1),
  localparam int SW = $clog2(2 * FACES + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          roll_btn,
  input logic          win,
  input logic          lose,
  input logic [DW-1:0] die_a,
  input logic [DW-1:0] die_b,
  input logic [SW-1:0] point
);

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (die_a == DW'(1) && die_b == DW'(1) && point == '0 && !win && !lose));

  a_r2_face_range: assert property (@(posedge clk) disable iff (rst)
    (die_a >= DW'(1) && die_a <= DW'(FACES) && die_b >= DW'(1) && die_b <= DW'(FACES)));

  a_r3_hold_released: assert property (@(posedge clk) disable iff (rst)
    !roll_btn |=> ($stable(die_a) && $stable(die_b)));

  a_r6_point_once: assert property (@(posedge clk) disable iff (rst)
    (point != '0) |=> $stable(point));

  a_r9_frozen_result: assert property (@(posedge clk) disable iff (rst)
    (win || lose) |=> ($stable(die_a) && $stable(die_b) && $stable(point) && $stable(win) && $stable(lose)));

  a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(win && lose));

  a_r11_no_light_while_held: assert property (@(posedge clk) disable iff (rst)
    (roll_btn && !win && !lose) |=> (!win && !lose));

endmodule

bind dice_game dice_game_chk #(.FACES(FACES)) u_chk (
  .clk(clk), .rst(rst), .roll_btn(roll_btn), .win(win), .lose(lose),
  .die_a(die_a), .die_b(die_b), .point(point)
);

// File: tb/tb_dice_game.sv
`timescale 1ns/1ps
module tb_dice_game;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic roll_btn = 1'b0;
  logic win, lose;
  logic [2:0] die_a, die_b;
  logic [3:0] point;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference model state
  int ma = 1, mb = 1, mp = 0, mres = 0;
  bit mfirst = 1, mheld = 0;

  always #5 clk = ~clk;

  dice_game dut (.clk(clk), .rst(rst), .roll_btn(roll_btn), .win(win), .lose(lose),
                 .die_a(die_a), .die_b(die_b), .point(point));

  always @(posedge clk) begin
    if (rst) begin
      ma = 1; mb = 1; mp = 0; mres = 0; mfirst = 1; mheld = 0;
    end else if (mres == 0) begin
      if (!roll_btn && mheld) begin
        if (mfirst) begin
          if (ma + mb == 7 || ma + mb == 11) mres = 1;
          else if (ma + mb == 2 || ma + mb == 3 || ma + mb == 12) mres = 2;
          else begin mp = ma + mb; mfirst = 0; end
        end else begin
          if (ma + mb == mp) mres = 1;
          else if (ma + mb == 7) mres = 2;
        end
      end
      if (roll_btn) begin
        mheld = 1;
        if (ma == 6) begin ma = 1; mb = (mb == 6) ? 1 : mb + 1; end
        else ma = ma + 1;
      end else mheld = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 die_a", int'(die_a), ma);
    chk("R2 die_b", int'(die_b), mb);
    chk("R6 point", int'(point), mp);
    chk("R11 win", int'(win), int'(mres == 1));
    chk("R11 lose", int'(lose), int'(mres == 2));
    chk("R10 exclusive", int'(win && lose), 0);
  endtask

  task automatic step(bit b);
    @(negedge clk);
    compare_all();
    roll_btn = b;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    roll_btn = 1'b0;
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic roll_to(int target);
    int a = ma, b = mb, n = 0;
    for (int i = 1; i <= 36; i++) begin
      if (a == 6) begin a = 1; b = (b == 6) ? 1 : b + 1; end
      else a = a + 1;
      if (a + b == target) begin n = i; break; end
    end
    repeat (n) step(1'b1);
    step(1'b0);
    step(1'b0);
  endtask

  initial begin
    int sa, sb;
    do_reset();
    @(negedge clk);
    chk("R1 die_a", int'(die_a), 1);
    chk("R1 die_b", int'(die_b), 1);
    chk("R1 point", int'(point), 0);
    chk("R1 lights", int'({win, lose}), 0);

    // full 36-step cycle returns to (1,1): sum 2 on opening roll
    repeat (36) step(1'b1);
    step(1'b0);
    chk("R2 wrap die_a", int'(die_a), 1);
    chk("R2 wrap die_b", int'(die_b), 1);
    chk("R11 not yet", int'(lose), 0);
    step(1'b0);
    chk("R5 lose on 2", int'(lose), 1);

    do_reset();
    roll_to(7);
    chk("R4 win on 7", int'(win), 1);
    sa = die_a; sb = die_b;
    repeat (5) step(1'b1);
    repeat (2) step(1'b0);
    chk("R9 die_a frozen", int'(die_a), sa);
    chk("R9 die_b frozen", int'(die_b), sb);
    chk("R9 win held", int'(win), 1);

    do_reset();
    roll_to(11);
    chk("R4 win on 11", int'(win), 1);
    do_reset();
    roll_to(3);
    chk("R5 lose on 3", int'(lose), 1);
    do_reset();
    roll_to(12);
    chk("R5 lose on 12", int'(lose), 1);

    do_reset();
    roll_to(5);
    chk("R6 point 5", int'(point), 5);
    chk("R6 no light", int'({win, lose}), 0);
    sa = die_a; sb = die_b;
    repeat (4) step(1'b0);
    chk("R3 die_a held", int'(die_a), sa);
    chk("R3 die_b held", int'(die_b), sb);
    roll_to(8);
    chk("R8 continue", int'({win, lose}), 0);
    chk("R8 point kept", int'(point), 5);
    roll_to(11);
    chk("R8 continue on 11", int'({win, lose}), 0);
    roll_to(5);
    chk("R7 win on point", int'(win), 1);

    do_reset();
    roll_to(6);
    chk("R6 point 6", int'(point), 6);
    roll_to(12);
    chk("R8 continue on 12", int'({win, lose}), 0);
    roll_to(7);
    chk("R8 lose on 7", int'(lose), 1);
    chk("R8 point unchanged", int'(point), 6);

    do_reset();
    roll_to(9);
    do_reset();
    @(negedge clk);
    chk("R1 point cleared", int'(point), 0);
    chk("R1 lights cleared", int'({win, lose}), 0);

    repeat (3) step(1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule